// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Controller

This block gathers interrupt requests from a parameterised set of sources and offers at most one of them at a time to a processor core. Each source carries a two-bit level code that gives it low, medium or high priority, or masks it. Each source has its own vector address. The address is built from a group base plus a slot offset within the group, so no two sources share a vector. The core takes the offered request by raising an acknowledge. The block then records the level as in service. A later return strobe unwinds the most urgent level that is in service.

The three levels nest. A level can enter only while no level at or above it is in service, so a more urgent level preempts a less urgent one. Each level has its own enable. A global enable gates entry only while nothing is in service. Medium and high requests resolve by source index. Low requests resolve by source index too, or, when rotation is selected, round-robin so that the last low source served is tried last. The offered request is registered, which makes the response time a fixed single cycle.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_valid` is 0 and `act_lvl` is 3'b000.
- R2: When an eligible request appears while nothing is offered, `irq_valid` rises exactly one clock later, together with that source's vector and level.
- R3: The vector of source i is VEC_BASE + (i / GRP_SIZE) * GRP_STRIDE + (i % GRP_SIZE) * SUB_STRIDE. With the defaults (0x040, 2, 16, 4) these are 0x40, 0x44, 0x50, 0x54, 0x60, 0x64, 0x70 and 0x74 for sources 0 to 7.
- R4: Source i's level code is `src_lvl[2i+1:2i]`: 1 is low, 2 is medium, 3 is high and 0 is masked. A masked source is never offered, and `irq_level` is never 0 while `irq_valid` is 1.
- R5: When several levels are eligible, the highest one is offered.
- R6: Within the medium and high levels, and within the low level when `low_rr` is 0, the lowest requesting index is offered.
- R7: When `low_rr` is 1, the low-level search begins at the index after the last acknowledged low source and wraps around. After reset the search starts at index 0.
- R8: A level whose enable bit `lvl_en[L-1]` is 0 is never offered.
- R9: A level is offered only if `act_lvl` has no bit set at that level or above. A higher level is still offered while a lower level is in service.
- R10: When `glob_en` is 0, no entry is offered while `act_lvl` is zero. Nested entries above an active level are still offered.
- R11: An acknowledge while `irq_valid` is 1 sets `act_lvl[irq_level-1]`, and `irq_valid` is 0 in the following cycle.
- R12: Each `irq_ret` pulse clears the highest set bit of `act_lvl` and only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request line of each source, held until serviced |
| src_lvl | input | 2*N_SRC | Two-bit level code per source (0 masked, 1 low, 2 medium, 3 high) |
| lvl_en | input | 3 | Enable per level, bit 0 low to bit 2 high |
| glob_en | input | 1 | Global enable for entry from the idle state |
| low_rr | input | 1 | 1 selects round-robin among low requests |
| irq_ack | input | 1 | Core takes the offered request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | VEC_W | Vector address of the offered source |
| irq_level | output | 2 | Level of the offered source |
| act_lvl | output | 3 | Levels in service, bit 0 low to bit 2 high |

## Verification
The assertions check several rules on every cycle. An offered level never has an in-service level at or above it. The offered level is never the masked code. The offer drops in the cycle after an acknowledge. An acknowledge marks its level in service, and a return removes exactly one in-service bit. Both arbiters always pick a requesting source, and the fixed-order one picks the lowest. The bench scenarios show what these per-cycle rules cannot: the exact vector values, the one-cycle latency, which source wins among mixed levels, the rotation order across successive low services, and that disabled levels, masked sources and the idle global enable hold off an entry that would otherwise happen.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    LVL_OFF = 2'd0,
    LVL_LO  = 2'd1,
    LVL_MD  = 2'd2,
    LVL_HI  = 2'd3
  } lvl_e;

  // Vector address: group base plus slot offset within the group.
  function automatic int unsigned vec_of(input int unsigned idx, input int unsigned base,
                                         input int unsigned per_grp, input int unsigned gstride,
                                         input int unsigned sstride);
    return base + (idx / per_grp) * gstride + (idx % per_grp) * sstride;
  endfunction

  // Mask of the level bits at lvl and above (lvl 1..3); 0 gives none.
  function automatic logic [2:0] at_or_above(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return 3'b111;
      2'd2:    return 3'b110;
      2'd3:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // One-hot of the highest set bit.
  function automatic logic [2:0] top_bit(input logic [2:0] a);
    if (a[2]) return 3'b100;
    if (a[1]) return 3'b010;
    if (a[0]) return 3'b001;
    return 3'b000;
  endfunction

endpackage

// File: rtl/irqc_fixed_arb.sv
module irqc_fixed_arb #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
  assign any = |req;

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx) - N'(1);

  // R6: the chosen index requests and nothing below it does
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & below_mask) == '0)));

endmodule

// File: rtl/irqc_rr_arb.sv
module irqc_rr_arb #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          rr_en,
  input  logic          adv,
  input  logic [IW-1:0] adv_idx,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] last_q;
  logic [IW-1:0] fix_idx, rot_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IW'(N - 1);
    else if (adv) last_q <= adv_idx;
  end

  always_comb begin
    fix_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) fix_idx = IW'(i);
  end

  // The scan runs from far to near so that the nearest hit after last_q is kept.
  always_comb begin
    rot_idx = '0;
    for (int k = N; k >= 1; k--)
      if (req[(int'(last_q) + k) % N]) rot_idx = IW'((int'(last_q) + k) % N);
  end

  assign any = |req;
  assign idx = rr_en ? rot_idx : fix_idx;

  // R7: the pick always belongs to a requesting source
  a_r7_pick_requests: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);
  // R7: the source just served loses to any other requester under rotation
  a_r7_served_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_en && any && (req & ~(N'(1) << last_q)) != '0) |-> idx != last_q);

endmodule

// File: rtl/irqc_active_stack.sv
module irqc_active_stack
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic [1:0] set_lvl,
  input  logic       ret,
  output logic [2:0] act
);

  logic [2:0] set_mask, clr_mask;
  assign set_mask = set_en ? (3'b001 << (set_lvl - 2'd1)) : 3'b000;
  assign clr_mask = ret ? top_bit(act) : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) act <= 3'b000;
    else        act <= (act | set_mask) & ~clr_mask;
  end

  // R11: an acknowledge marks its level in service
  a_r11_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !ret) |=> act[$past(set_lvl) - 2'd1]);
  // R12: a return removes exactly one in-service bit
  a_r12_one_bit_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !set_en && act != 3'b000) |=> $countones(act) == $countones($past(act)) - 1);
  // R12: a return never touches bits below the top one
  a_r12_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !set_en && act[2]) |=> act[1:0] == $past(act[1:0]));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 'h040,
  parameter int GRP_SIZE   = 2,
  parameter int GRP_STRIDE = 16,
  parameter int SUB_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   irq_req,
  input  logic [2*N_SRC-1:0] src_lvl,
  input  logic [2:0]         lvl_en,
  input  logic               glob_en,
  input  logic               low_rr,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [1:0]         irq_level,
  output logic [2:0]         act_lvl
);

  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [2:0]      any_l;
  logic [3*IW-1:0] idx_l;
  logic [2:0]      elig;
  logic            ack_fire;
  logic [IW-1:0]   cur_idx;
  logic            pick_any;
  logic [1:0]      pick_lvl;
  logic [IW-1:0]   pick_idx;
  logic [VEC_W-1:0] pick_vec;

  assign ack_fire = irq_valid && irq_ack;

  genvar g;
  for (g = 0; g < 3; g++) begin : g_lvl
    logic [N_SRC-1:0] lq;
    logic             a;
    logic [IW-1:0]    ix;
    always_comb
      for (int i = 0; i < N_SRC; i++)
        lq[i] = irq_req[i] && (src_lvl[2*i +: 2] == 2'(g + 1));
    if (g == 0) begin : g_rot
      irqc_rr_arb #(.N(N_SRC), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(lq), .rr_en(low_rr),
        .adv(ack_fire && irq_level == LVL_LO), .adv_idx(cur_idx),
        .any(a), .idx(ix));
    end else begin : g_fix
      irqc_fixed_arb #(.N(N_SRC), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(lq), .any(a), .idx(ix));
    end
    assign any_l[g] = a;
    assign idx_l[g*IW +: IW] = ix;
    assign elig[g] = a && lvl_en[g]
                     && ((act_lvl & at_or_above(2'(g + 1))) == 3'b000)
                     && (glob_en || act_lvl != 3'b000);
  end

  always_comb begin
    pick_any = |elig;
    pick_lvl = LVL_OFF;
    pick_idx = '0;
    if (elig[2])      begin pick_lvl = LVL_HI; pick_idx = idx_l[2*IW +: IW]; end
    else if (elig[1]) begin pick_lvl = LVL_MD; pick_idx = idx_l[1*IW +: IW]; end
    else if (elig[0]) begin pick_lvl = LVL_LO; pick_idx = idx_l[0 +: IW]; end
    pick_vec = VEC_W'(vec_of(int'(pick_idx), VEC_BASE, GRP_SIZE, GRP_STRIDE, SUB_STRIDE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= LVL_OFF;
      cur_idx    <= '0;
    end else if (ack_fire) begin
      irq_valid  <= 1'b0;
    end else begin
      irq_valid  <= pick_any;
      irq_vector <= pick_vec;
      irq_level  <= pick_lvl;
      cur_idx    <= pick_idx;
    end
  end

  irqc_active_stack u_stack (
    .clk(clk), .rst_n(rst_n), .set_en(ack_fire), .set_lvl(irq_level),
    .ret(irq_ret), .act(act_lvl));

  // R11: the offer is withdrawn in the cycle after it is taken
  a_r11_quiet_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_valid);
  // R9: nothing at or above the offered level is in service
  a_r9_no_block_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (act_lvl & at_or_above(irq_level)) == 3'b000);
  // R4: the masked code is never offered
  a_r4_level_coded: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != LVL_OFF);
  // R10: an entry from idle needs the global enable
  a_r10_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !$past(irq_valid) && $past(act_lvl) == 3'b000) |-> $past(glob_en));

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  localparam int N    = 8;
  localparam int BASE = 'h040;
  localparam int GRP  = 2;
  localparam int GST  = 16;
  localparam int SST  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [2*N-1:0] src_lvl = '0;
  logic [2:0]    lvl_en = 3'b111;
  logic          glob_en = 1'b1;
  logic          low_rr = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_ret = 1'b0;
  logic          irq_valid;
  logic [11:0]   irq_vector;
  logic [1:0]    irq_level;
  logic [2:0]    act_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .src_lvl(src_lvl),
    .lvl_en(lvl_en), .glob_en(glob_en), .low_rr(low_rr),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .act_lvl(act_lvl));

  // Vector model, built by walking the slots one at a time.
  function automatic int exp_vec(input int idx);
    int v = BASE;
    for (int j = 0; j < idx; j++)
      if ((j + 1) % GRP == 0) v += GST - (GRP - 1) * SST;
      else v += SST;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Scoreboard queues
  int    q_vec[$];
  int    q_lvl[$];
  string q_tag[$];

  always @(posedge clk) begin
    if (rst_n && irq_valid && irq_ack) begin
      if (q_vec.size() == 0) begin
        chk(0, "R2 unexpected offer", int'(irq_vector), 0);
      end else begin
        int ev, el;
        string t;
        ev = q_vec.pop_front();
        el = q_lvl.pop_front();
        t  = q_tag.pop_front();
        chk(int'(irq_vector) == ev, {t, " vector"}, int'(irq_vector), ev);
        chk(int'(irq_level) == el, {t, " level"}, int'(irq_level), el);
      end
    end
  end

  task automatic setsrc(input int i, input int l, input bit r);
    src_lvl[2*i +: 2] = 2'(l);
    irq_req[i] = r;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait for an offer, take it and confirm the in-service bit (R11).
  task automatic take(input int idx, input int lvl, input string tag);
    int w = 0;
    q_vec.push_back(exp_vec(idx));
    q_lvl.push_back(lvl);
    q_tag.push_back(tag);
    while (!irq_valid && w < 30) begin
      @(negedge clk);
      w++;
    end
    if (!irq_valid) begin
      chk(0, {tag, " no offer"}, 0, 1);
      void'(q_vec.pop_front()); void'(q_lvl.pop_front()); void'(q_tag.pop_front());
    end else begin
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(act_lvl[lvl-1] == 1'b1, "R11 level marked", int'(act_lvl), lvl);
      chk(irq_valid == 1'b0, "R11 offer withdrawn", int'(irq_valid), 0);
    end
  endtask

  task automatic ret_once();
    irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk(irq_valid == 1'b0, "R1 valid", int'(irq_valid), 0);
    chk(act_lvl == 3'b000, "R1 act", int'(act_lvl), 0);

    // R2 / R3: one-cycle latency and vector of source 3
    setsrc(3, 1, 1);
    @(negedge clk);
    chk(irq_valid == 1'b1, "R2 latency", int'(irq_valid), 1);
    chk(irq_vector == 12'h054, "R3 vector src3", int'(irq_vector), 'h54);
    take(3, 1, "R3");
    setsrc(3, 1, 0);

    // R9: same level blocked, higher level preempts
    setsrc(0, 1, 1);
    idle(4);
    chk(irq_valid == 1'b0, "R9 same level held", int'(irq_valid), 0);
    setsrc(5, 2, 1);
    take(5, 2, "R9 preempt");
    setsrc(5, 2, 0);
    chk(act_lvl == 3'b011, "R9 nested", int'(act_lvl), 3);

    // R12: returns unwind from the top
    ret_once();
    chk(act_lvl == 3'b001, "R12 top cleared", int'(act_lvl), 1);
    ret_once();
    chk(act_lvl == 3'b000, "R12 all clear", int'(act_lvl), 0);
    take(0, 1, "R9 pending low");
    setsrc(0, 1, 0);
    ret_once();

    // R5 / R6: mixed levels
    setsrc(6, 3, 1); setsrc(2, 3, 1); setsrc(1, 1, 1); setsrc(4, 2, 1);
    idle(2);
    take(2, 3, "R6 high lowest index"); setsrc(2, 3, 0); ret_once();
    take(6, 3, "R5 high next");         setsrc(6, 3, 0); ret_once();
    take(4, 2, "R5 medium");            setsrc(4, 2, 0); ret_once();
    take(1, 1, "R5 low last");          setsrc(1, 1, 0); ret_once();
    chk(act_lvl == 3'b000, "R12 empty", int'(act_lvl), 0);

    // R8: disabled level
    lvl_en = 3'b011;
    setsrc(7, 3, 1);
    idle(5);
    chk(irq_valid == 1'b0, "R8 disabled high", int'(irq_valid), 0);
    lvl_en = 3'b111;
    take(7, 3, "R8 enabled");
    setsrc(7, 3, 0);
    ret_once();

    // R4: masked source
    setsrc(3, 0, 1);
    idle(5);
    chk(irq_valid == 1'b0, "R4 masked", int'(irq_valid), 0);
    setsrc(3, 0, 0);

    // R10: global enable
    glob_en = 1'b0;
    setsrc(0, 1, 1);
    idle(5);
    chk(irq_valid == 1'b0, "R10 idle gated", int'(irq_valid), 0);
    glob_en = 1'b1;
    take(0, 1, "R10 released");
    glob_en = 1'b0;
    setsrc(5, 2, 1);
    take(5, 2, "R10 nested ungated");
    setsrc(5, 2, 0); setsrc(0, 1, 0);
    ret_once(); ret_once();
    glob_en = 1'b1;

    // R7: rotation (last low served is source 0)
    low_rr = 1'b1;
    setsrc(1, 1, 1); setsrc(4, 1, 1); setsrc(6, 1, 1);
    idle(2);
    take(1, 1, "R7 after 0"); ret_once();
    take(4, 1, "R7 after 1"); ret_once();
    take(6, 1, "R7 after 4"); ret_once();
    take(1, 1, "R7 wrap");    ret_once();
    low_rr = 1'b0;
    take(1, 1, "R6 fixed low"); ret_once();
    take(1, 1, "R6 fixed low again"); ret_once();
    setsrc(1, 1, 0); setsrc(4, 1, 0); setsrc(6, 1, 0);
    idle(3);
    chk(q_vec.size() == 0, "R2 scoreboard drained", q_vec.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule